// File: doc/BRIEF.md
# Line Rasterizing Step Engine

This block walks a straight line one pixel at a time, using error terms that software has already worked out. A host loads four configuration words through a simple write port while the engine is idle. The words hold the signed start point, the pixel count together with the starting error, the two signed error increments, and three mode bits. A start strobe then launches the walk. The engine does not compute slopes, clip, or touch memory. It accumulates the supplied increments, decides on each step whether the minor axis moves, and hands out one coordinate pair per valid/ready handshake.

A downstream pixel writer takes coordinates at its own pace through `pix_ready`. When the last coordinate has been accepted, `done` pulses for one cycle and the engine returns to idle. A count of zero skips the walk and produces only the `done` pulse.

Top module: `vls_line_stepper`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `pix_valid` and `done` are low, and `pix_valid` is never high while `busy` is low.
- R2: Idle writes land by address. Address 0 holds start Y in bits 31:16 and start X in bits 15:0, both signed. Address 1 holds the count in bits 29:16 and the unsigned starting error in bits 15:0. Address 2 holds the signed increment for non-diagonal steps in bits 31:16 and the signed increment for diagonal steps in bits 15:0. Address 3 holds the mode: bit 0 makes X step down, bit 1 makes Y step down, and bit 2 makes Y the major axis.
- R3: A start strobe while idle raises `pix_valid` in the next cycle, and the first coordinate presented is exactly the loaded start point.
- R4: After each handshake the major-axis coordinate moves by one in its direction, wrapping in 16 bits. If the accumulator was non-negative, the minor axis also moves by one in its direction.
- R5: The accumulator is 17-bit signed. The starting error is zero-extended into it. On each handshake it adds the sign-extended diagonal increment when it was non-negative and the sign-extended non-diagonal increment otherwise, wrapping in 17 bits.
- R6: Exactly count handshakes are accepted. `done` is high for exactly one cycle, the cycle after the last handshake, and never together with `pix_valid`.
- R7: With a count of zero, no coordinate is presented and `done` pulses in the cycle after the start strobe.
- R8: While `pix_valid` is high and `pix_ready` is low, `pix_valid` stays high and the coordinate holds.
- R9: While `busy` is high, configuration writes and start strobes have no effect. The running walk is unchanged, and the stored words are unchanged for later starts.
- R10: Bits 31:30 of address 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 2 | Configuration word select |
| cfg_wdata | input | 32 | Configuration write data |
| start | input | 1 | Launch strobe, taken only when idle |
| pix_ready | input | 1 | Consumer accepts the presented coordinate |
| pix_valid | output | 1 | A coordinate is presented |
| pix_x | output | 16 | Current X coordinate, two's complement |
| pix_y | output | 16 | Current Y coordinate, two's complement |
| busy | output | 1 | A walk or its closing `done` cycle is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong accumulator sign or a wrong increment choice shows up as a minor-axis coordinate that differs from the model on the very next accepted pixel. Because every step feeds the following one, the error then persists for the rest of the line. A miscounted length appears as an extra or missing handshake and as a `done` pulse that lands one cycle early or late. A lost stall shows as a coordinate that changes while `pix_ready` is low, in the same cycle it happens. Comparing `pix_x`, `pix_y`, `pix_valid`, `busy` and `done` on every cycle therefore exposes most internal faults within one handshake of their cause.

// File: rtl/vls_pkg.sv
// Shared constants and types for the line step engine.
// Assumes a 32-bit configuration word holding two 16-bit halves.
package vls_pkg;
    localparam int VLS_DATA_W  = 32;
    localparam int VLS_COORD_W = 16;
    localparam int VLS_LEN_W   = 14;
    localparam int VLS_ERR_W   = 16;
    localparam int VLS_ADDR_W  = 2;

    // Word select codes on the configuration port
    localparam logic [VLS_ADDR_W-1:0] VLS_REG_ORIGIN = 2'd0;
    localparam logic [VLS_ADDR_W-1:0] VLS_REG_LEN    = 2'd1;
    localparam logic [VLS_ADDR_W-1:0] VLS_REG_ERR    = 2'd2;
    localparam logic [VLS_ADDR_W-1:0] VLS_REG_MODE   = 2'd3;

    // Mode word bit positions
    localparam int VLS_MODE_XNEG = 0;
    localparam int VLS_MODE_YNEG = 1;
    localparam int VLS_MODE_YMAJ = 2;

    typedef enum logic [1:0] {
        VLS_IDLE = 2'd0,
        VLS_RUN  = 2'd1,
        VLS_FIN  = 2'd2
    } vls_state_e;
endpackage

// File: rtl/vls_regs.sv
// Configuration store. Captures host words by address while unlocked.
// Assumes the caller holds lock high for the whole walk so fields stay stable.
module vls_regs
    import vls_pkg::*;
#(
    parameter int DATA_W  = VLS_DATA_W,
    parameter int ADDR_W  = VLS_ADDR_W,
    parameter int COORD_W = VLS_COORD_W,
    parameter int LEN_W   = VLS_LEN_W,
    parameter int ERR_W   = VLS_ERR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               lock,
    output logic [COORD_W-1:0] org_x,
    output logic [COORD_W-1:0] org_y,
    output logic [LEN_W-1:0]   len,
    output logic [ERR_W-1:0]   init_err,
    output logic [ERR_W-1:0]   axial_inc,
    output logic [ERR_W-1:0]   diag_inc,
    output logic               xneg,
    output logic               yneg,
    output logic               ymaj
);
    localparam int HALF = DATA_W / 2;

    // Store each field when its word is written and the store is unlocked
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            org_x     <= '0;
            org_y     <= '0;
            len       <= '0;
            init_err  <= '0;
            axial_inc <= '0;
            diag_inc  <= '0;
            xneg      <= 1'b0;
            yneg      <= 1'b0;
            ymaj      <= 1'b0;
        end else if (we && !lock) begin
            case (addr)
                VLS_REG_ORIGIN: begin
                    org_x <= wdata[0 +: COORD_W];
                    org_y <= wdata[HALF +: COORD_W];
                end
                VLS_REG_LEN: begin
                    init_err <= wdata[0 +: ERR_W];
                    len      <= wdata[HALF +: LEN_W];
                end
                VLS_REG_ERR: begin
                    diag_inc  <= wdata[0 +: ERR_W];
                    axial_inc <= wdata[HALF +: ERR_W];
                end
                default: begin
                    xneg <= wdata[VLS_MODE_XNEG];
                    yneg <= wdata[VLS_MODE_YNEG];
                    ymaj <= wdata[VLS_MODE_YMAJ];
                end
            endcase
        end
    end
endmodule

// File: rtl/vls_err_acc.sv
// Error accumulator. Loads the zero-extended starting error and adds one
// sign-extended increment per advance. Assumes load and adv never coincide.
module vls_err_acc #(
    parameter int ERR_W = 16,
    localparam int ACC_W = ERR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ERR_W-1:0] init_err,
    input  logic             adv,
    input  logic [ERR_W-1:0] axial_inc,
    input  logic [ERR_W-1:0] diag_inc,
    output logic             nonneg
);
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] inc;

    // Pick the increment from the current sign and widen it
    always_comb begin
        nonneg = ~acc[ACC_W-1];
        inc    = nonneg ? {diag_inc[ERR_W-1], diag_inc}
                        : {axial_inc[ERR_W-1], axial_inc};
    end

    // Load at launch and accumulate on each accepted pixel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (load) begin
            acc <= {1'b0, init_err};
        end else if (adv) begin
            acc <= acc + inc;
        end
    end
endmodule

// File: rtl/vls_axis_step.sv
// One coordinate axis. Loads a start value and steps by one in either
// direction. Wraps modulo 2**W. Assumes load and adv never coincide.
module vls_axis_step #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] start_val,
    input  logic         adv,
    input  logic         neg,
    output logic [W-1:0] coord
);
    // Hold, load, or move the coordinate by one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coord <= '0;
        end else if (load) begin
            coord <= start_val;
        end else if (adv) begin
            coord <= neg ? coord - W'(1) : coord + W'(1);
        end
    end
endmodule

// File: rtl/vls_seq.sv
// Walk sequencer. Counts remaining pixels and produces the valid window and
// the one-cycle closing pulse. Start is honoured only in the idle state.
module vls_seq
    import vls_pkg::*;
#(
    parameter int LEN_W = VLS_LEN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    input  logic             ready,
    output logic             load,
    output logic             hs,
    output logic             valid,
    output logic             busy,
    output logic             done
);
    vls_state_e       state;
    logic [LEN_W-1:0] remain;

    // Decode state into the port-facing controls
    always_comb begin
        valid = (state == VLS_RUN);
        done  = (state == VLS_FIN);
        busy  = (state != VLS_IDLE);
        load  = (state == VLS_IDLE) && start;
        hs    = valid && ready;
    end

    // Advance the walk: launch, count down on handshakes, then close
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= VLS_IDLE;
            remain <= '0;
        end else begin
            case (state)
                VLS_IDLE: begin
                    if (start) begin
                        remain <= len;
                        state  <= (len == '0) ? VLS_FIN : VLS_RUN;
                    end
                end
                VLS_RUN: begin
                    if (ready) begin
                        remain <= remain - LEN_W'(1);
                        if (remain == LEN_W'(1)) begin
                            state <= VLS_FIN;
                        end
                    end
                end
                default: state <= VLS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/vls_line_stepper.sv
// Top of the line step engine. Takes configuration words, latches the
// direction mode at launch and walks the line one handshake at a time.
// Assumes software supplies consistent error terms.
module vls_line_stepper
    import vls_pkg::*;
#(
    parameter int DATA_W  = VLS_DATA_W,
    parameter int ADDR_W  = VLS_ADDR_W,
    parameter int COORD_W = VLS_COORD_W,
    parameter int LEN_W   = VLS_LEN_W,
    parameter int ERR_W   = VLS_ERR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [DATA_W-1:0]  cfg_wdata,
    input  logic               start,
    input  logic               pix_ready,
    output logic               pix_valid,
    output logic [COORD_W-1:0] pix_x,
    output logic [COORD_W-1:0] pix_y,
    output logic               busy,
    output logic               done
);
    localparam int N_AXES = 2;

    logic [COORD_W-1:0] org_x, org_y;
    logic [LEN_W-1:0]   len;
    logic [ERR_W-1:0]   init_err, axial_inc, diag_inc;
    logic               cfg_xneg, cfg_yneg, cfg_ymaj;
    logic               run_xneg, run_yneg, run_ymaj;
    logic               load, hs, nonneg;

    logic [COORD_W-1:0] ax_start [N_AXES];
    logic [COORD_W-1:0] ax_coord [N_AXES];
    logic               ax_neg   [N_AXES];
    logic               ax_adv   [N_AXES];

    vls_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .COORD_W(COORD_W),
        .LEN_W(LEN_W), .ERR_W(ERR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .lock(busy),
        .org_x(org_x), .org_y(org_y), .len(len), .init_err(init_err),
        .axial_inc(axial_inc), .diag_inc(diag_inc),
        .xneg(cfg_xneg), .yneg(cfg_yneg), .ymaj(cfg_ymaj)
    );

    vls_seq #(.LEN_W(LEN_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .len(len),
        .ready(pix_ready), .load(load), .hs(hs), .valid(pix_valid),
        .busy(busy), .done(done)
    );

    vls_err_acc #(.ERR_W(ERR_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .load(load), .init_err(init_err),
        .adv(hs), .axial_inc(axial_inc), .diag_inc(diag_inc),
        .nonneg(nonneg)
    );

    // Latch the direction mode at launch so it holds for the whole walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_xneg <= 1'b0;
            run_yneg <= 1'b0;
            run_ymaj <= 1'b0;
        end else if (load) begin
            run_xneg <= cfg_xneg;
            run_yneg <= cfg_yneg;
            run_ymaj <= cfg_ymaj;
        end
    end

    // Route per-axis start values, directions and step enables
    always_comb begin
        ax_start[0] = org_x;
        ax_start[1] = org_y;
        ax_neg[0]   = run_xneg;
        ax_neg[1]   = run_yneg;
        ax_adv[0]   = hs && (!run_ymaj || nonneg);
        ax_adv[1]   = hs && ( run_ymaj || nonneg);
    end

    for (genvar a = 0; a < N_AXES; a++) begin : g_axis
        vls_axis_step #(.W(COORD_W)) u_axis (
            .clk(clk), .rst_n(rst_n), .load(load),
            .start_val(ax_start[a]), .adv(ax_adv[a]), .neg(ax_neg[a]),
            .coord(ax_coord[a])
        );
    end

    assign pix_x = ax_coord[0];
    assign pix_y = ax_coord[1];
endmodule

// File: rtl/vls_line_stepper_chk.sv
// Property checker for the line step engine, attached with bind.
module vls_line_stepper_chk #(
    parameter int COORD_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pix_valid,
    input logic               pix_ready,
    input logic [COORD_W-1:0] pix_x,
    input logic [COORD_W-1:0] pix_y,
    input logic               busy,
    input logic               done,
    input logic               run_xneg,
    input logic               run_yneg,
    input logic               run_ymaj
);
    localparam logic [COORD_W-1:0] ONE  = COORD_W'(1);
    localparam logic [COORD_W-1:0] MONE = {COORD_W{1'b1}};

    AST_IDLE_NO_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !pix_valid);  // R1

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_x) && $stable(pix_y)));  // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R6

    AST_DONE_NO_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !pix_valid);  // R6

    AST_MAJOR_X_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_ready && !run_ymaj) |=>
        (pix_x == $past(pix_x) + ($past(run_xneg) ? MONE : ONE)));  // R4

    AST_MAJOR_Y_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_ready && run_ymaj) |=>
        (pix_y == $past(pix_y) + ($past(run_yneg) ? MONE : ONE)));  // R4
endmodule

bind vls_line_stepper vls_line_stepper_chk #(.COORD_W(COORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_x(pix_x), .pix_y(pix_y), .busy(busy), .done(done),
    .run_xneg(run_xneg), .run_yneg(run_yneg), .run_ymaj(run_ymaj)
);

// File: tb/tb_vls_line_stepper.sv
module tb_vls_line_stepper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        start = 1'b0;
    logic        pix_ready = 1'b1;
    logic        pix_valid, busy, done;
    logic [15:0] pix_x, pix_y;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int ready_mode = 0;     // 0 always, 1 pseudo-random, 2 held low
    logic [15:0] lfsr = 16'hACE1;

    vls_line_stepper dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .start(start), .pix_ready(pix_ready),
        .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y),
        .busy(busy), .done(done)
    );

    always #2 clk = ~clk;

    // Behavioural reference state
    logic [31:0] r_word [4];
    int  m_phase = 0;       // 0 idle, 1 walking, 2 closing
    int  m_x = 0, m_y = 0, m_acc = 0, m_cnt = 0;
    bit  m_xneg = 0, m_yneg = 0, m_ymaj = 0;
    bit  armed = 0;
    int  hs_count = 0;
    int  first_x = 0, first_y = 0;

    function automatic int sx16(input logic [15:0] v);
        return int'($signed(v));
    endfunction

    function automatic int wrapn(input int v, input int bits);
        int m;
        m = v & ((1 << bits) - 1);
        if (m >= (1 << (bits - 1))) m = m - (1 << bits);
        return m;
    endfunction

    function automatic void check(input bit ok, input string req, input string what,
                                  input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endfunction

    // Reference model and handshake capture on each rising edge
    always @(posedge clk) begin
        bit nonneg;
        cycles++;
        armed = 1;
        if (pix_valid && pix_ready && rst_n) begin
            if (hs_count == 0) begin
                first_x = sx16(pix_x);
                first_y = sx16(pix_y);
            end
            hs_count++;
        end
        if (!rst_n) begin
            m_phase = 0;
            for (int i = 0; i < 4; i++) r_word[i] = '0;
        end else begin
            case (m_phase)
                0: begin
                    if (start) begin
                        m_x    = sx16(r_word[0][15:0]);
                        m_y    = sx16(r_word[0][31:16]);
                        m_cnt  = int'(r_word[1][29:16]);
                        m_acc  = int'(r_word[1][15:0]);
                        m_xneg = r_word[3][0];
                        m_yneg = r_word[3][1];
                        m_ymaj = r_word[3][2];
                        m_phase = (m_cnt == 0) ? 2 : 1;
                    end
                    if (cfg_we) r_word[cfg_addr] = cfg_wdata;
                end
                1: begin
                    if (pix_ready) begin
                        nonneg = (m_acc >= 0);
                        if (m_ymaj || nonneg) m_y = wrapn(m_y + (m_yneg ? -1 : 1), 16);
                        if (!m_ymaj || nonneg) m_x = wrapn(m_x + (m_xneg ? -1 : 1), 16);
                        m_acc = wrapn(m_acc + (nonneg ? sx16(r_word[2][15:0])
                                                      : sx16(r_word[2][31:16])), 17);
                        m_cnt--;
                        if (m_cnt == 0) m_phase = 2;
                    end
                end
                default: m_phase = 0;
            endcase
        end
        if (cycles > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Cycle-by-cycle comparison and ready stimulus on falling edges
    always @(negedge clk) begin
        if (armed && rst_n) begin
            check(busy == (m_phase != 0), "R1", "busy", int'(busy), int'(m_phase != 0));
            check(pix_valid == (m_phase == 1), "R6", "pix_valid", int'(pix_valid), int'(m_phase == 1));
            check(done == (m_phase == 2), "R6", "done", int'(done), int'(m_phase == 2));
            if (m_phase == 1) begin
                check(sx16(pix_x) == m_x, "R4", "pix_x", sx16(pix_x), m_x);
                check(sx16(pix_y) == m_y, "R5", "pix_y", sx16(pix_y), m_y);
            end
        end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        pix_ready = (ready_mode == 0) ? 1'b1 : (ready_mode == 2) ? 1'b0 : lfsr[0];
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic kick();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int n;
        n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
    endtask

    task automatic run_line(input logic [31:0] org, input logic [31:0] lw,
                            input logic [31:0] ew, input logic [31:0] mw,
                            input int mode, input int exp_len, input string req);
        wr(2'd0, org); wr(2'd1, lw); wr(2'd2, ew); wr(2'd3, mw);
        ready_mode = mode;
        hs_count = 0;
        kick();
        if (exp_len > 0)
            check(pix_valid == 1'b1, "R3", "valid after start", int'(pix_valid), 1);
        else
            check(done == 1'b1 && pix_valid == 1'b0, "R7", "done after start", int'(done), 1);
        wait_done();
        check(hs_count == exp_len, req, "handshake count", hs_count, exp_len);
        if (exp_len > 0) begin
            check(first_x == sx16(org[15:0]), "R3", "first x", first_x, sx16(org[15:0]));
            check(first_y == sx16(org[31:16]), "R2", "first y", first_y, sx16(org[31:16]));
        end
        ready_mode = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 0 && pix_valid == 0 && done == 0, "R1", "reset outputs",
              int'({busy, pix_valid, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // X-major, positive directions, free-flowing consumer (R2, R4)
        run_line({16'd10, 16'd20}, {2'b00, 14'd6, 16'd3}, {16'd4, 16'hFFFA}, 32'h0, 0, 6, "R6");
        // Y-major, both directions negative, random stalls (R4, R8)
        run_line({16'd100, 16'hFFFB}, {2'b00, 14'd9, 16'd0}, {16'd2, 16'hFFF8}, 32'h7, 1, 9, "R8");
        // Zero count: done only (R7)
        run_line({16'd1, 16'd1}, {2'b00, 14'd0, 16'd5}, 32'h0, 32'h0, 0, 0, "R7");
        // Reserved bits set in the count word (R10)
        run_line({16'd3, 16'd3}, {2'b11, 14'd4, 16'd1}, {16'd1, 16'hFFFF}, 32'h2, 0, 4, "R10");
        // Large zero-extended start error and wide increments (R5)
        run_line({16'd0, 16'd0}, {2'b00, 14'd20, 16'hFFFF}, {16'h7FFF, 16'h8AD0}, 32'h1, 1, 20, "R5");
        // X coordinate wraps past the positive limit (R4)
        run_line({16'd7, 16'h7FFE}, {2'b00, 14'd5, 16'd0}, {16'hFFFF, 16'hFFFE}, 32'h0, 0, 5, "R4");

        // Writes and starts during a walk are ignored (R9)
        wr(2'd0, {16'd50, 16'd60}); wr(2'd1, {2'b00, 14'd8, 16'd2});
        wr(2'd2, {16'd3, 16'hFFFC}); wr(2'd3, 32'h0);
        ready_mode = 2;
        hs_count = 0;
        kick();
        wr(2'd0, {16'd999, 16'd888});
        wr(2'd1, {2'b00, 14'd2, 16'd0});
        kick();
        ready_mode = 1;
        wait_done();
        check(hs_count == 8, "R9", "count after busy writes", hs_count, 8);
        check(first_x == 60, "R9", "first x after busy writes", first_x, 60);
        ready_mode = 0;
        hs_count = 0;
        kick();
        wait_done();
        check(hs_count == 8, "R9", "stored count kept", hs_count, 8);
        check(first_y == 50, "R9", "stored origin kept", first_y, 50);

        repeat (4) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule